// File: doc/BRIEF.md
# Receive destination address filter

This block decides, for each received Ethernet frame, whether the MAC should keep it. The decision is based on the frame's 48-bit destination address. It keeps a small table of programmable station addresses and a per-entry enable mask. A command word selects which frame classes pass: unicast, multicast, broadcast and table hits. It can also invert the table result, so that a matching address is the one that gets rejected.

Software loads the table, the mask and the command word through a simple write port. It uses 32-bit words at byte offsets; the address bits [1:0] are ignored. The receive path presents a destination address with a one-cycle strobe. One clock later the block returns a registered verdict. It also returns whether any enabled entry matched and the lowest index that did. A typical setup enables table compare together with broadcast and unicast acceptance, with entry 0 holding the station's own address.

Top module: `mac_dest_filter`

## Requirements
- R1: After reset, res_valid, res_accept, res_hit and res_index are 0, every entry, the enable mask and the command word are 0, so any presented address is rejected.
- R2: res_valid pulses for exactly one cycle, in the cycle after each da_valid cycle. res_accept, res_hit and res_index change only at that point and hold their values between strobes. Back-to-back strobes give back-to-back results.
- R3: Entry i's high word is at byte offset 8*i and its low word at 8*i+4, for i = 0..15. The high word holds address bytes 0..3, byte 0 in bits 31:24. Bits 31:16 of the low word hold bytes 4 and 5, and bits 15:0 are discarded. On the da port, byte 0 is da[47:40] and byte 5 is da[7:0].
- R4: The enable word at offset 0x80 has bit i for entry i. An entry whose bit is 0 never produces a match.
- R5: Command bit 2 accepts broadcast, meaning all 48 address bits are 1.
- R6: Command bit 1 accepts multicast, meaning da[40] is 1 and the address is not broadcast. A broadcast is not accepted by bit 1 alone.
- R7: Command bit 0 accepts every unicast address, meaning da[40] is 0.
- R8: The command word is at offset 0x84, bits 4:0. When bit 4 (compare enable) is set, an address that equals an enabled entry is accepted. When all command bits are 0, nothing is accepted.
- R9: Command bit 3 inverts the table result before it is used. With compare enabled, a hit then rejects and a miss accepts. With compare disabled, bit 3 alone accepts nothing.
- R10: res_hit is 1 when any enabled entry equals the address, independent of bit 3. res_index gives the lowest such entry, and is 0 when there is no hit.
- R11: A register write in the same cycle as da_valid does not affect that address's result. It applies from the next strobe on.
- R12: Writes to word offsets above 0x84 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register byte offset |
| wr_data | input | 32 | Register write data |
| da_valid | input | 1 | Destination address strobe |
| da | input | 48 | Destination address, byte 0 in bits 47:40 |
| res_valid | output | 1 | Result pulse, one cycle after da_valid |
| res_accept | output | 1 | Frame accepted |
| res_hit | output | 1 | An enabled entry matched |
| res_index | output | 4 | Lowest matching entry |

## Verification
The bench aims at the corner cases that separate the address classes, because a design that mixes them up would fail in specific ways:
- A design that tested only the group bit would let bit 1 alone accept broadcast.
- A design that kept the low half of the low word would fail to match an entry written with junk in bits 15:0.

Two more cases target the table result:
- Duplicate entries at indices 5 and 9 expose a priority encoder that favours the highest index.
- Complement mode with compare disabled exposes an inversion applied outside the compare gate.

The last case is timing. A command write issued in the strobe cycle catches a design that samples registers one cycle late. A long random run, including writes to unmapped offsets, is compared against a behavioural model on every clock.

// File: rtl/daf_pkg.sv
package daf_pkg;
   localparam int MAC_W   = 48;
   localparam int DATA_W  = 32;
   localparam int CMD_W   = 5;
   // command bit positions
   localparam int CB_UNI   = 0;
   localparam int CB_MULTI = 1;
   localparam int CB_BCAST = 2;
   localparam int CB_INV   = 3;
   localparam int CB_CMP   = 4;
   // position of the group bit within the address
   localparam int GROUP_BIT = MAC_W - 8;

   typedef enum logic [1:0] {
      CLS_UNI   = 2'd0,
      CLS_MULTI = 2'd1,
      CLS_BCAST = 2'd2
   } addr_class_t;

   function automatic addr_class_t classify(input logic [MAC_W-1:0] a);
      if (&a)              return CLS_BCAST;
      else if (a[GROUP_BIT]) return CLS_MULTI;
      else                 return CLS_UNI;
   endfunction
endpackage

// File: rtl/daf_regfile.sv
module daf_regfile
   import daf_pkg::*;
#(
   parameter int N_ENTRIES = 16,
   parameter int ADDR_W    = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [ADDR_W-1:0]          wr_addr,
   input  logic [DATA_W-1:0]          wr_data,
   output logic [N_ENTRIES-1:0][MAC_W-1:0] tbl,
   output logic [N_ENTRIES-1:0]       ent_en,
   output logic [CMD_W-1:0]           cmd
);
   localparam int WORD_W  = ADDR_W - 2;
   localparam int HI_W    = DATA_W;
   localparam int LO_W    = MAC_W - DATA_W;
   localparam logic [WORD_W-1:0] EN_WORD  = WORD_W'(2 * N_ENTRIES);
   localparam logic [WORD_W-1:0] CMD_WORD = WORD_W'(2 * N_ENTRIES + 1);

   logic [WORD_W-1:0] wr_word;
   logic              unused_bits;
   assign wr_word     = wr_addr[ADDR_W-1:2];
   assign unused_bits = ^wr_addr[1:0];

   for (genvar i = 0; i < N_ENTRIES; i++) begin : g_ent
      localparam logic [WORD_W-1:0] BASE = WORD_W'(2 * i);
      logic [HI_W-1:0] hi_q;
      logic [LO_W-1:0] lo_q;
      logic            sel;
      assign sel = wr_en && ({wr_word[WORD_W-1:1], 1'b0} == BASE);
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            hi_q <= '0;
            lo_q <= '0;
         end else if (sel) begin
            if (wr_word[0]) lo_q <= wr_data[DATA_W-1 -: LO_W];
            else            hi_q <= wr_data;
         end
      end
      assign tbl[i] = {hi_q, lo_q};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ent_en <= '0;
         cmd    <= '0;
      end else if (wr_en) begin
         if (wr_word == EN_WORD)  ent_en <= wr_data[N_ENTRIES-1:0];
         if (wr_word == CMD_WORD) cmd    <= wr_data[CMD_W-1:0];
      end
   end
endmodule

// File: rtl/daf_match_array.sv
module daf_match_array
   import daf_pkg::*;
#(
   parameter int N_ENTRIES = 16,
   parameter int IDX_W     = 4
) (
   input  logic [N_ENTRIES-1:0][MAC_W-1:0] tbl,
   input  logic [N_ENTRIES-1:0]            ent_en,
   input  logic [MAC_W-1:0]                da,
   output logic                            hit,
   output logic [IDX_W-1:0]                idx
);
   logic [N_ENTRIES-1:0] eq;

   for (genvar i = 0; i < N_ENTRIES; i++) begin : g_cmp
      assign eq[i] = ent_en[i] && (tbl[i] == da);
   end

   // scan from the top so the lowest index is written last
   always_comb begin
      idx = '0;
      for (int i = N_ENTRIES - 1; i >= 0; i--) begin
         if (eq[i]) idx = IDX_W'(i);
      end
   end

   assign hit = |eq;
endmodule

// File: rtl/daf_decide.sv
module daf_decide
   import daf_pkg::*;
(
   input  logic [MAC_W-1:0] da,
   input  logic             hit,
   input  logic [CMD_W-1:0] cmd,
   output logic             accept
);
   addr_class_t cls;
   logic        class_ok;
   logic        table_ok;

   assign cls = classify(da);

   always_comb begin
      unique case (cls)
         CLS_BCAST: class_ok = cmd[CB_BCAST];
         CLS_MULTI: class_ok = cmd[CB_MULTI];
         default:   class_ok = cmd[CB_UNI];
      endcase
   end

   assign table_ok = cmd[CB_CMP] && (hit ^ cmd[CB_INV]);
   assign accept   = class_ok || table_ok;
endmodule

// File: rtl/mac_dest_filter.sv
module mac_dest_filter
   import daf_pkg::*;
#(
   parameter int N_ENTRIES = 16,
   parameter int ADDR_W    = 8,
   parameter int IDX_W     = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [31:0]       wr_data,
   input  logic              da_valid,
   input  logic [47:0]       da,
   output logic              res_valid,
   output logic              res_accept,
   output logic              res_hit,
   output logic [IDX_W-1:0]  res_index
);
   if (N_ENTRIES < 1 || N_ENTRIES > DATA_W) begin : g_bad_n
      $error("N_ENTRIES must be 1..32");
   end
   if ((2 ** (ADDR_W - 2)) < (2 * N_ENTRIES + 2)) begin : g_bad_aw
      $error("ADDR_W too small for the register map");
   end
   if ((2 ** IDX_W) < N_ENTRIES) begin : g_bad_iw
      $error("IDX_W too small for N_ENTRIES");
   end

   logic [N_ENTRIES-1:0][MAC_W-1:0] tbl;
   logic [N_ENTRIES-1:0]            en_r;
   logic [CMD_W-1:0]                cmd_r;
   logic                            hit_c;
   logic [IDX_W-1:0]                idx_c;
   logic                            acc_c;

   daf_regfile #(.N_ENTRIES(N_ENTRIES), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .tbl(tbl), .ent_en(en_r), .cmd(cmd_r)
   );

   daf_match_array #(.N_ENTRIES(N_ENTRIES), .IDX_W(IDX_W)) u_match (
      .tbl(tbl), .ent_en(en_r), .da(da), .hit(hit_c), .idx(idx_c)
   );

   daf_decide u_dec (
      .da(da), .hit(hit_c), .cmd(cmd_r), .accept(acc_c)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid  <= 1'b0;
         res_accept <= 1'b0;
         res_hit    <= 1'b0;
         res_index  <= '0;
      end else begin
         res_valid <= da_valid;
         if (da_valid) begin
            res_accept <= acc_c;
            res_hit    <= hit_c;
            res_index  <= idx_c;
         end
      end
   end
endmodule

// File: rtl/daf_checker.sv
module daf_checker #(
   parameter int IDX_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             da_valid,
   input logic [47:0]      da,
   input logic [4:0]       cmd,
   input logic             res_valid,
   input logic             res_accept,
   input logic             res_hit,
   input logic [IDX_W-1:0] res_index
);
   AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      da_valid |=> res_valid); // R2
   AST_NO_STRAY_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      !da_valid |=> !res_valid); // R2
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !da_valid |=> $stable(res_accept) && $stable(res_hit) && $stable(res_index)); // R2
   AST_NO_HIT_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid && !res_hit |-> res_index == '0); // R10
   AST_BCAST_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      da_valid && (&da) && cmd[2] |=> res_accept); // R5
   AST_UNI_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      da_valid && !da[40] && cmd[0] |=> res_accept); // R7
   AST_CMD_ZERO_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
      da_valid && cmd == 5'd0 |=> !res_accept); // R8
endmodule

bind mac_dest_filter daf_checker #(.IDX_W(IDX_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .da_valid(da_valid), .da(da), .cmd(cmd_r),
   .res_valid(res_valid), .res_accept(res_accept), .res_hit(res_hit),
   .res_index(res_index)
);

// File: tb/sim_mac_dest_filter.sv
module sim_mac_dest_filter;
   localparam int CLK_PERIOD = 10;
   localparam int NE = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        da_valid = 1'b0;
   logic [47:0] da = '0;
   logic        res_valid, res_accept, res_hit;
   logic [3:0]  res_index;

   int checks = 0;
   int failures = 0;
   string cur_req = "R1";
   bit done = 0;

   mac_dest_filter u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .da_valid(da_valid), .da(da),
      .res_valid(res_valid), .res_accept(res_accept), .res_hit(res_hit),
      .res_index(res_index)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   // behavioural reference model
   logic [31:0] m_hi [NE];
   logic [15:0] m_lo [NE];
   logic [31:0] m_en;
   logic [4:0]  m_cmd;
   logic        e_valid, e_acc, e_hit;
   int          e_idx;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NE; i++) begin m_hi[i] = 0; m_lo[i] = 0; end
         m_en = 0; m_cmd = 0;
         e_valid = 0; e_acc = 0; e_hit = 0; e_idx = 0;
      end else begin
         e_valid = da_valid;
         if (da_valid) begin
            bit bc, mc, uc, h;
            int first;
            bc = (da == {48{1'b1}});
            mc = da[40] && !bc;
            uc = !da[40];
            h = 0; first = 0;
            for (int i = NE - 1; i >= 0; i--)
               if (m_en[i] && {m_hi[i], m_lo[i]} == da) begin h = 1; first = i; end
            e_hit = h;
            e_idx = first;
            e_acc = (uc && m_cmd[0]) || (mc && m_cmd[1]) || (bc && m_cmd[2]) ||
                    (m_cmd[4] && (h ^ m_cmd[3]));
         end
         if (wr_en) begin
            int w;
            w = int'(wr_addr[7:2]);
            if (w < 2 * NE) begin
               if (w % 2 == 0) m_hi[w / 2] = wr_data;
               else            m_lo[w / 2] = wr_data[31:16];
            end else if (w == 2 * NE)     m_en = {16'd0, wr_data[15:0]};
            else if (w == 2 * NE + 1)     m_cmd = wr_data[4:0];
         end
      end
   end

   // compare on every clock, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         checks++;
         if (res_valid !== e_valid || res_accept !== e_acc || res_hit !== e_hit ||
             int'(res_index) != e_idx) begin
            failures++;
            $display("FAIL %s model: got v=%0b a=%0b h=%0b i=%0d exp v=%0b a=%0b h=%0b i=%0d",
                     cur_req, res_valid, res_accept, res_hit, res_index,
                     e_valid, e_acc, e_hit, e_idx);
         end
      end
   end

   task automatic chk(input string req, input logic acc, input logic hit, input int idx);
      checks++;
      if (res_valid !== 1'b1 || res_accept !== acc || res_hit !== hit || int'(res_index) != idx) begin
         failures++;
         $display("FAIL %s: got v=%0b a=%0b h=%0b i=%0d exp v=1 a=%0b h=%0b i=%0d",
                  req, res_valid, res_accept, res_hit, res_index, acc, hit, idx);
      end
   endtask

   task automatic cyc(input logic we, input int wa, input logic [31:0] wd,
                      input logic dv, input logic [47:0] d);
      wr_en = we; wr_addr = wa[7:0]; wr_data = wd; da_valid = dv; da = d;
      @(negedge clk);
      wr_en = 0; da_valid = 0;
   endtask

   task automatic wr(input int wa, input logic [31:0] wd);
      cyc(1, wa, wd, 0, '0);
   endtask

   task automatic look(input logic [47:0] d);
      cyc(0, 0, 0, 1, d);
   endtask

   task automatic put(input int e, input logic [47:0] a);
      wr(8 * e, a[47:16]);
      wr(8 * e + 4, {a[15:0], 16'hABCD});
   endtask

   localparam logic [47:0] A  = 48'h02_11_22_33_44_55;
   localparam logic [47:0] B  = 48'h00_AA_BB_CC_DD_EE;
   localparam logic [47:0] C  = 48'h04_10_20_30_40_50;
   localparam logic [47:0] BC = 48'hFF_FF_FF_FF_FF_FF;
   localparam logic [47:0] MC = 48'h01_00_5E_00_00_01;
   localparam int EN_OFS = 8'h80;
   localparam int CMD_OFS = 8'h84;

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1: reset state
      checks++;
      if (res_valid !== 0 || res_accept !== 0 || res_hit !== 0 || res_index !== 0) begin
         failures++;
         $display("FAIL R1 reset outputs: got %0b%0b%0b%0d exp 0000",
                  res_valid, res_accept, res_hit, res_index);
      end
      look(A); chk("R1", 0, 0, 0);
      look(BC); chk("R1", 0, 0, 0);

      // R3 / R8: entry 0 with junk in low bits, compare enabled
      cur_req = "R3";
      put(0, A);
      wr(EN_OFS, 32'h1);
      wr(CMD_OFS, 32'h10);
      look(A); chk("R3", 1, 1, 0);
      look(A ^ 48'h1); chk("R8", 0, 0, 0);

      // R2: back-to-back strobes then idle hold
      cur_req = "R2";
      look(A); chk("R2", 1, 1, 0);
      look(B); chk("R2", 0, 0, 0);
      cyc(0, 0, 0, 0, A);
      checks++;
      if (res_valid !== 0 || res_accept !== 0) begin
         failures++;
         $display("FAIL R2 idle: got v=%0b a=%0b exp v=0 a=0", res_valid, res_accept);
      end

      // R4: disabled entry
      cur_req = "R4";
      wr(EN_OFS, 32'h0);
      look(A); chk("R4", 0, 0, 0);

      // R10: duplicates at 5 and 9, lowest wins
      cur_req = "R10";
      put(5, B); put(9, B); put(15, C);
      wr(EN_OFS, 32'h8221);
      look(B); chk("R10", 1, 1, 5);
      look(C); chk("R10", 1, 1, 15);
      wr(EN_OFS, 32'h8201);
      look(B); chk("R10", 1, 1, 9);

      // R5 / R6 / R7: class acceptance
      cur_req = "R5";
      wr(CMD_OFS, 32'h04);
      look(BC); chk("R5", 1, 0, 0);
      look(MC); chk("R5", 0, 0, 0);
      cur_req = "R6";
      wr(CMD_OFS, 32'h02);
      look(MC); chk("R6", 1, 0, 0);
      look(BC); chk("R6", 0, 0, 0);
      look(A); chk("R6", 0, 1, 0);
      cur_req = "R7";
      wr(CMD_OFS, 32'h01);
      look(48'h00_12_34_56_78_9A); chk("R7", 1, 0, 0);
      look(MC); chk("R7", 0, 0, 0);

      // R9: complement
      cur_req = "R9";
      wr(CMD_OFS, 32'h18);
      look(A); chk("R9", 0, 1, 0);
      look(48'h00_12_34_56_78_9A); chk("R9", 1, 0, 0);
      wr(CMD_OFS, 32'h08);
      look(48'h00_12_34_56_78_9A); chk("R9", 0, 0, 0);

      // R11: write in the same cycle as the strobe
      cur_req = "R11";
      wr(CMD_OFS, 32'h10);
      cyc(1, CMD_OFS, 32'h0, 1, A); chk("R11", 1, 1, 0);
      look(A); chk("R11", 0, 1, 0);

      // R12: unmapped offsets
      cur_req = "R12";
      wr(CMD_OFS, 32'h10);
      wr(8'h88, 32'hFFFF_FFFF);
      wr(8'hFC, 32'hFFFF_FFFF);
      look(A); chk("R12", 1, 1, 0);
      look(BC); chk("R12", 0, 0, 0);

      // random phase against the model
      cur_req = "R2/R10 random";
      for (int n = 0; n < 2000; n++) begin
         logic [47:0] d;
         int sel, wa;
         sel = $urandom_range(0, 5);
         case (sel)
            0: d = A; 1: d = B; 2: d = C; 3: d = BC; 4: d = MC;
            default: d = {$urandom, $urandom};
         endcase
         wa = $urandom_range(0, 63) * 4;
         if ($urandom_range(0, 3) == 0) begin
            case ($urandom_range(0, 3))
               0: wa = EN_OFS;
               1: wa = CMD_OFS;
               default: ;
            endcase
         end
         cyc($urandom_range(0, 2) == 0, wa,
             ($urandom_range(0, 1) == 0) ? {A[47:16]} : $urandom,
             $urandom_range(0, 1) == 1, d);
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      failures++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule